// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block runs the two-wire management link to an Ethernet PHY. It takes one command at a time on a simple parallel interface: a read or write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. It then generates the management clock (MDC) and shifts a complete Clause 22 frame over the data line (MDIO). The data line has three pins: an output value, an output enable that controls an external tri-state buffer, and an input from the pad. When the frame is finished, the block pulses `done`. A read returns its 16-bit result on `rd_data`.

Every frame lasts 64 MDC periods. A write drives all 64 bits: a run of ones, a fixed 16-bit opcode word that holds both addresses, then the data. A read drives the ones and the first 14 opcode bits. It then releases the line for the two turnaround bits and for the 16 data bits that the PHY returns. A small tracker can be enabled by a parameter. It copies the link-status bit each time a read of the PHY status register completes.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_o` is 1, `mdio_oe` is 1, `busy`, `done` and `link_up` are 0, and `rd_data` is 0.
- R2: When `cmd_valid` is high while `busy` is low, the command is accepted and `busy` is high from the next cycle until the cycle of the `done` pulse. A `cmd_valid` that arrives while `busy` is high starts no frame and produces no `done`.
- R3: While a frame runs, MDC is low for CLK_HALF cycles and then high for CLK_HALF cycles in every bit. The default of 10 gives 2.5 MHz from a 50 MHz clock. MDC stays low while the block is idle.
- R4: Every frame begins with PRE_LEN (default 32) bit times of `mdio_o` = 1 with `mdio_oe` = 1.
- R5: After the ones, a write drives, MSB first, the 16-bit word {4'b0101, phy[4:0], reg[4:0], 2'b10}. It then drives `cmd_wdata` MSB first, with `mdio_oe` = 1 for all 64 bits.
- R6: After the ones, a read drives the 14 bits {4'b0110, phy[4:0], reg[4:0]}, MSB first. It then holds `mdio_oe` at 0 for the remaining 18 bit times (2 turnaround bits and 16 data bits), low phases included.
- R7: A read samples `mdio_i` in the cycle in which MDC rises, in bit times PRE_LEN+16 through PRE_LEN+31. The first sample is rd_data[15]. `rd_data` takes the result in the `done` cycle and holds it until the next read completes.
- R8: `mdio_o` changes only in cycles where MDC is low. When a read completes, `mdio_oe` returns to 1 in the same cycle as `done`.
- R9: `done` is a single-cycle pulse that rises exactly 128*CLK_HALF cycles after the clock edge that accepted the command. `busy` falls in that same cycle.
- R10: One cycle after `done`, a completed read of register 1 sets `link_up` to rd_data[2]. All other transactions leave `link_up` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, sampled when not busy |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Result of the last completed read |
| link_up | output | 1 | Link-status bit from the last read of register 1 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable for the external tri-state buffer |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
Each frame ends a fixed 128*CLK_HALF cycles after the accepting edge. The bench records that edge for every queued command and requires `done` at exactly that count. It then checks `done` low one cycle later and `link_up` one cycle after that. The bit stream is captured in the cycle in which MDC is seen to rise, which is the moment the block itself samples `mdio_i`. The emulated PHY changes `mdio_i` right after each rise, so the value is settled a full bit time before the next sample. MDC phase lengths and the changes of `mdio_o` are compared against cycle counts on every falling clock edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mdio_state_e;

    localparam int          ADDR_W   = 5;
    localparam int          DATA_W   = 16;
    localparam int          OPW_W    = 16;
    localparam logic [3:0]  HEAD_WR  = 4'b0101;
    localparam logic [3:0]  HEAD_RD  = 4'b0110;
    localparam logic [1:0]  TAIL_WR  = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CLK_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d    = gen_q;
        rise_stb = 1'b0;
        fall_stb = 1'b0;
        if (!run) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else if (gen_q.cnt == CNT_LAST) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
            rise_stb  = ~gen_q.mdc;
            fall_stb  = gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign mdc = gen_q.mdc;

    // R3: the clock parks low once the sequencer stops requesting it
    a_r3_parks_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    // R3: a rise strobe always leads to a high clock on the next cycle
    a_r3_rise_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              last_read,
    output logic [ADDR_W-1:0] last_reg,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int FRAME     = PRE_LEN + OPW_W + DATA_W;
    localparam int IW        = $clog2(FRAME) + 1;
    localparam int RD_DRIVEN = PRE_LEN + OPW_W - 2;
    localparam int RD_SAMPLE = PRE_LEN + OPW_W;
    localparam logic [IW-1:0] IDX_LAST   = IW'(FRAME - 1);
    localparam logic [IW-1:0] IDX_RELEASE = IW'(RD_DRIVEN);
    localparam logic [IW-1:0] IDX_SAMPLE = IW'(RD_SAMPLE);

    typedef struct packed {
        mdio_state_e       state;
        logic [IW-1:0]     idx;
        logic [FRAME-1:0]  tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] rd_data;
        logic              rd;
        logic [ADDR_W-1:0] rg;
        logic              o;
        logic              oe;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [FRAME-1:0] tx_shift;
    logic [IW-1:0]    idx_next;

    assign tx_shift = seq_q.tx << 1;
    assign idx_next = seq_q.idx + 1'b1;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.state = ST_RUN;
                    seq_d.idx   = '0;
                    seq_d.rd    = cmd_read;
                    seq_d.rg    = cmd_reg;
                    seq_d.rx    = '0;
                    seq_d.o     = 1'b1;
                    seq_d.oe    = 1'b1;
                    if (cmd_read) begin
                        seq_d.tx = {{PRE_LEN{1'b1}}, HEAD_RD, cmd_phy, cmd_reg,
                                    {(DATA_W + 2){1'b0}}};
                    end else begin
                        seq_d.tx = {{PRE_LEN{1'b1}}, HEAD_WR, cmd_phy, cmd_reg,
                                    TAIL_WR, cmd_wdata};
                    end
                end
            end
            default: begin
                if (rise_stb && seq_q.rd && (seq_q.idx >= IDX_SAMPLE)) begin
                    seq_d.rx = {seq_q.rx[DATA_W-2:0], mdio_i};
                end
                if (fall_stb) begin
                    if (seq_q.idx == IDX_LAST) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.o     = 1'b1;
                        seq_d.oe    = 1'b1;
                        if (seq_q.rd) begin
                            seq_d.rd_data = seq_q.rx;
                        end
                    end else begin
                        seq_d.idx = idx_next;
                        seq_d.tx  = tx_shift;
                        seq_d.o   = tx_shift[FRAME-1];
                        seq_d.oe  = !(seq_q.rd && (idx_next >= IDX_RELEASE));
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= ST_IDLE;
            seq_q.o     <= 1'b1;
            seq_q.oe    <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.state == ST_RUN);
    assign done      = seq_q.done;
    assign rd_data   = seq_q.rd_data;
    assign last_read = seq_q.rd;
    assign last_reg  = seq_q.rg;
    assign mdio_o    = seq_q.o;
    assign mdio_oe   = seq_q.oe;

    // R9: the completion strobe lasts exactly one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: busy has already dropped when done is shown
    a_r2_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2: busy only ends through a completed frame
    a_r2_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: the driver comes back on only at frame completion
    a_r8_oe_back_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> done);

    // R6: the line is released only inside a read frame
    a_r6_release_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_oe |-> (busy && seq_q.rd));

    // R7: read data moves only in the completion cycle
    a_r7_rd_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);

endmodule

// File: rtl/mdio_link_track.sv
module mdio_link_track
    import mdio_pkg::*;
#(
    parameter int LINK_REG = 1,
    parameter int LINK_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic              last_read,
    input  logic [ADDR_W-1:0] last_reg,
    input  logic [DATA_W-1:0] rd_data,
    output logic              link_up
);

    localparam logic [ADDR_W-1:0] STATUS_REG = ADDR_W'(LINK_REG);

    logic link_d, link_q;

    always_comb begin
        link_d = link_q;
        if (done && last_read && (last_reg == STATUS_REG)) begin
            link_d = rd_data[LINK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= 1'b0;
        end else begin
            link_q <= link_d;
        end
    end

    assign link_up = link_q;

    // R10: the flag moves only right after a completed frame
    a_r10_link_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_up) |-> $past(done));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HALF = 10,
    parameter int PRE_LEN  = 32,
    parameter bit LINK_EN  = 1'b1,
    parameter int LINK_REG = 1,
    parameter int LINK_BIT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_read,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        link_up,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    logic              rise_stb;
    logic              fall_stb;
    logic              last_read;
    logic [ADDR_W-1:0] last_reg;

    mdio_mdc_gen #(
        .CLK_HALF (CLK_HALF)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .last_read (last_read),
        .last_reg  (last_reg),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    generate
        if (LINK_EN) begin : g_link
            mdio_link_track #(
                .LINK_REG (LINK_REG),
                .LINK_BIT (LINK_BIT)
            ) u_link (
                .clk       (clk),
                .rst_n     (rst_n),
                .done      (done),
                .last_read (last_read),
                .last_reg  (last_reg),
                .rd_data   (rd_data),
                .link_up   (link_up)
            );
        end else begin : g_nolink
            assign link_up = 1'b0;
        end
    endgenerate

    // R8: data changes are placed in the low phase of the management clock
    a_r8_o_moves_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> !mdc);

    // R3: no clock activity outside a frame
    a_r3_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    localparam int H      = 10;
    localparam int FRAME_CYC = 128 * H;

    typedef struct {
        bit        rd;
        bit [4:0]  phy;
        bit [4:0]  rg;
        bit [15:0] wd;
        bit [15:0] pv;
        bit        exp_link;
        int        start;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, link_up, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i = 1'b1;

    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   done_cnt = 0;
    int   pushed = 0;
    bit   mlink = 1'b0;
    bit [15:0] phy_val = '0;
    item_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdio_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .link_up   (link_up),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input bit rd, input bit [4:0] phy, input bit [4:0] rg,
                          input bit [15:0] wd, input bit [15:0] pv);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        if (rd && rg == 5'd1) mlink = pv[2];
        it.rd = rd; it.phy = phy; it.rg = rg; it.wd = wd; it.pv = pv;
        it.exp_link = mlink;
        it.start = cyc + 1;
        phy_val = pv;
        exp_q.push_back(it);
        pushed++;
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Monitor: emulated PHY plus scoreboard
    initial begin : monitor
        bit [63:0] cap_o, cap_oe;
        int  rc, last_rise, last_fall;
        bit  prev_mdc, prev_o, mdc_bad, o_bad, pend_pulse, pend_link;
        bit  link_exp;
        item_t it;
        rc = 0; last_rise = 0; last_fall = 0; prev_mdc = 0; prev_o = 1;
        mdc_bad = 0; o_bad = 0; pend_pulse = 0; pend_link = 0; link_exp = 0;
        cap_o = '0; cap_oe = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            if (pend_link) begin
                check(link_up == link_exp, "R10 link_up", link_up, link_exp);
                pend_link = 0;
            end
            if (pend_pulse) begin
                check(!done, "R9 done single pulse", done, 0);
                pend_pulse = 0;
                pend_link = 1;
            end
            if (mdio_o != prev_o && mdc) o_bad = 1;
            if (mdc && !prev_mdc) begin
                if (rc > 0 && cyc - last_fall != H) mdc_bad = 1;
                last_rise = cyc;
                cap_o[63 - rc] = mdio_o;
                cap_oe[63 - rc] = mdio_oe;
                rc++;
                mdio_i = (rc >= 48 && rc < 64) ? phy_val[63 - rc] : 1'b1;
            end
            if (!mdc && prev_mdc) begin
                if (cyc - last_rise != H) mdc_bad = 1;
                last_fall = cyc;
            end
            if (!busy && mdc) mdc_bad = 1;
            prev_mdc = mdc;
            prev_o = mdio_o;
            if (done) begin
                done_cnt++;
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected done", 1, 0);
                end else begin
                    it = exp_q.pop_front();
                    check(cyc - it.start == FRAME_CYC, "R9 frame length", cyc - it.start, FRAME_CYC);
                    check(!busy, "R9 busy falls with done", busy, 0);
                    check(rc == 64, "R3 MDC periods per frame", rc, 64);
                    check(!mdc_bad, "R3 MDC phase lengths", mdc_bad, 0);
                    check(!o_bad, "R8 mdio_o moves only with MDC low", o_bad, 0);
                    check(mdio_oe, "R8 driver enabled at done", mdio_oe, 1);
                    check(cap_o[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
                          "R4 preamble", cap_o[63:32], 32'hFFFF_FFFF);
                    if (!it.rd) begin
                        check(cap_o[31:16] == {4'b0101, it.phy, it.rg, 2'b10},
                              "R5 write opcode word", cap_o[31:16], {4'b0101, it.phy, it.rg, 2'b10});
                        check(cap_o[15:0] == it.wd, "R5 write data", cap_o[15:0], it.wd);
                        check(cap_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R5 write driven", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
                    end else begin
                        check(cap_o[31:18] == {4'b0110, it.phy, it.rg},
                              "R6 read opcode bits", cap_o[31:18], {4'b0110, it.phy, it.rg});
                        check(cap_oe == 64'hFFFF_FFFF_FFFC_0000, "R6 read release", cap_oe, 64'hFFFF_FFFF_FFFC_0000);
                        check(rd_data == it.pv, "R7 read data", rd_data, it.pv);
                    end
                    link_exp = it.exp_link;
                end
                pend_pulse = 1;
                rc = 0; mdc_bad = 0; o_bad = 0;
                mdio_i = 1'b1;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
        check(!mdc && mdio_o && mdio_oe, "R1 reset line state", {mdc, mdio_o, mdio_oe}, 3'b011);
        check(!link_up && rd_data == 16'h0, "R1 reset link/data", {link_up, rd_data}, 0);
        repeat (30) @(negedge clk);
        check(!mdc, "R3 MDC low while idle", mdc, 0);

        do_cmd(1'b0, 5'h01, 5'h04, 16'h0061, 16'h0);
        do_cmd(1'b0, 5'h1F, 5'h00, 16'h1000, 16'h0);
        do_cmd(1'b1, 5'h01, 5'h01, 16'h0, 16'h782D);
        do_cmd(1'b1, 5'h0A, 5'h05, 16'h0, 16'h0000);
        do_cmd(1'b1, 5'h15, 5'h01, 16'h0, 16'hA5A2);
        do_cmd(1'b0, 5'h03, 5'h1B, 16'hBEEF, 16'h0);
        // R2: a request during an active frame must be dropped
        repeat (200) @(negedge clk);
        check(busy, "R2 busy during frame", busy, 1);
        cmd_valid = 1'b1; cmd_read = 1'b1; cmd_phy = 5'h07; cmd_reg = 5'h02;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (FRAME_CYC + 20) @(negedge clk);
        check(done_cnt == pushed, "R2 ignored command gave no frame", done_cnt, pushed);
        check(!busy && !mdc, "R2 idle after ignored command", {busy, mdc}, 0);
        check(exp_q.size() == 0, "R9 all frames completed", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule